// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block keeps an EDO DRAM's contents alive by running CAS-before-RAS refresh cycles. The cycles are spread evenly in time, one per refresh interval. After reset it holds the memory bus through a long power-up pause. It then runs a fixed number of warm-up refresh cycles and raises a sticky init-done flag. From then on an interval timer adds one owed refresh per interval to a small pending counter. The block asks for the strobe bus with `bus_req` and starts a cycle only while the access controller returns `bus_gnt`. If the controller holds off, owed refreshes pile up to a limit and are then run back to back.

A low-power request moves the block into self-refresh. It runs one normal refresh, then starts a CAS-before-RAS cycle and keeps RAS and CAS low for at least a minimum time and for as long as the request stays high. When the request drops, it releases the strobes and holds RAS high for the longer self-refresh precharge. It then runs one more normal refresh and goes back to interval refresh. All timing is in clock cycles and set by parameters. The write-enable strobe is driven high at all times, so a refresh cycle can never enter test mode.

Top module: `dram_refresh_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `ras_n`, `cas_n` and `we_n` are 1, `init_done` is 0 and `bus_req` is 1.
- R2: For `PAUSE_CYC` cycles after reset, `ras_n` and `cas_n` stay high. `bus_req` stays high until `init_done`. `lp_req` has no effect before `init_done` rises.
- R3: After the pause, exactly `WARM_CYC` refresh cycles run without waiting for `bus_gnt`. `init_done` then rises and stays high until the next reset.
- R4: In every refresh cycle `cas_n` falls first and is low for `CAS_LEAD` cycles before `ras_n` falls. `cas_n` stays low for as long as `ras_n` is low, and both rise on the same edge.
- R5: `we_n` is high in every cycle, and in particular at every falling edge of `ras_n`.
- R6: A normal refresh cycle holds `ras_n` low for exactly `RAS_LOW` cycles. It is followed by at least `PRE_CYC` cycles with `ras_n` high.
- R7: In normal operation one refresh is owed every `INTERVAL` cycles. `bus_req` is high while a refresh is owed or a cycle is in progress, and low otherwise.
- R8: After `init_done`, a refresh cycle starts only in a cycle where `bus_gnt` is 1. While `bus_gnt` is 0 no strobe falls.
- R9: The count of owed refreshes saturates at `MAX_PEND`, and further interval ticks are dropped. Once the grant returns, the owed cycles run back to back with one idle cycle between them.
- R10: A high `lp_req` in normal operation leads, once the strobes are idle, to one normal refresh cycle (with grant) and then to self-refresh. Owed refreshes are discarded at that point.
- R11: In self-refresh, `ras_n` and `cas_n` stay low for at least `SREF_MIN` cycles and for as long as `lp_req` stays high. When `lp_req` is already low, they stay low for exactly `SREF_MIN` cycles.
- R12: After self-refresh, `ras_n` stays high for at least `SR_PRE_CYC` cycles. Then exactly one normal refresh runs, and normal interval operation resumes with the timer restarted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lp_req | input | 1 | Low-power request; high asks for self-refresh, low ends it |
| bus_gnt | input | 1 | Strobe bus granted by the access controller |
| ras_n | output | 1 | Row strobe to the DRAM, active low, registered |
| cas_n | output | 1 | Column strobe to the DRAM, active low, registered |
| we_n | output | 1 | Write strobe to the DRAM, held high |
| bus_req | output | 1 | Request for the strobe bus |
| init_done | output | 1 | Power-up sequence complete |

## Verification
The bench builds the block with a 40-cycle interval, a 30-cycle pause, a pending limit of 3, a two-cycle CAS lead, a 25-cycle self-refresh minimum and a 7-cycle self-refresh precharge. These values keep the full power-up sequence, several interval ticks and both self-refresh exits within a few hundred cycles. Withholding the grant for six intervals drives the pending counter into saturation, so dropped ticks show up as exactly three back-to-back cycles. The short low-power pulse lands exactly on the self-refresh minimum, and the long pulse shows the strobes held past it.

// File: rtl/drs_pkg.sv
package drs_pkg;

  typedef enum logic [2:0] {
    SQ_PAUSE,
    SQ_WARM,
    SQ_RUN,
    SQ_SR_PRE,
    SQ_SR_IN,
    SQ_SR_POST
  } seq_state_t;

  typedef enum logic [1:0] {
    EN_IDLE,
    EN_CAS,
    EN_RAS,
    EN_PRE
  } eng_state_t;

endpackage

// File: rtl/drs_tick_timer.sv
module drs_tick_timer #(
  parameter int INTERVAL = 1950
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int TW = $clog2(INTERVAL + 1);
  localparam logic [TW-1:0] T_LAST = TW'(INTERVAL - 1);

  logic [TW-1:0] cnt;

  assign tick = en && (cnt == T_LAST);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assert_count_in_range_R7: assert property (@(posedge clk) disable iff (rst)
    cnt <= T_LAST);

endmodule

// File: rtl/drs_pend_ctr.sv
module drs_pend_ctr #(
  parameter int MAX_PEND = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  input  logic dec,
  output logic any
);
  localparam int PW = $clog2(MAX_PEND + 1);
  localparam logic [PW-1:0] P_MAX = PW'(MAX_PEND);

  logic [PW-1:0] cnt;

  assign any = (cnt != '0);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (inc && !dec) begin
      if (cnt != P_MAX) cnt <= cnt + 1'b1;
    end else if (dec && !inc) begin
      cnt <= cnt - 1'b1;
    end
  end

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
    cnt <= P_MAX);

  assert_no_underflow_R9: assert property (@(posedge clk) disable iff (rst)
    (dec && !clr) |-> (cnt != '0));

endmodule

// File: rtl/drs_cbr_engine.sv
module drs_cbr_engine #(
  parameter int CAS_LEAD   = 1,
  parameter int RAS_LOW    = 8,
  parameter int PRE_CYC    = 5,
  parameter int SREF_MIN   = 12500,
  parameter int SR_PRE_CYC = 14
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic self_mode,
  input  logic hold,
  output logic ras_n,
  output logic cas_n,
  output logic busy,
  output logic done
);
  import drs_pkg::*;

  localparam int MA   = (CAS_LEAD > RAS_LOW) ? CAS_LEAD : RAS_LOW;
  localparam int MB   = (PRE_CYC > SR_PRE_CYC) ? PRE_CYC : SR_PRE_CYC;
  localparam int MC   = (MA > MB) ? MA : MB;
  localparam int MAXV = (MC > SREF_MIN) ? MC : SREF_MIN;
  localparam int CW   = $clog2(MAXV + 1);

  localparam logic [CW-1:0] LEAD_LAST = CW'(CAS_LEAD - 1);
  localparam logic [CW-1:0] RAS_LAST  = CW'(RAS_LOW - 1);
  localparam logic [CW-1:0] PRE_LAST  = CW'(PRE_CYC - 1);
  localparam logic [CW-1:0] SREF_LAST = CW'(SREF_MIN - 1);
  localparam logic [CW-1:0] SRP_LAST  = CW'(SR_PRE_CYC - 1);

  eng_state_t     st;
  logic [CW-1:0]  cnt;
  logic           self_q;
  logic [CW-1:0]  pre_last;
  logic           ras_end;

  assign busy     = (st != EN_IDLE);
  assign pre_last = self_q ? SRP_LAST : PRE_LAST;
  assign ras_end  = self_q ? ((cnt >= SREF_LAST) && !hold) : (cnt == RAS_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= EN_IDLE;
      cnt    <= '0;
      self_q <= 1'b0;
      ras_n  <= 1'b1;
      cas_n  <= 1'b1;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        EN_IDLE: begin
          if (start) begin
            st     <= EN_CAS;
            cnt    <= '0;
            cas_n  <= 1'b0;
            self_q <= self_mode;
          end
        end
        EN_CAS: begin
          if (cnt == LEAD_LAST) begin
            st    <= EN_RAS;
            cnt   <= '0;
            ras_n <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        EN_RAS: begin
          if (ras_end) begin
            st    <= EN_PRE;
            cnt   <= '0;
            ras_n <= 1'b1;
            cas_n <= 1'b1;
          end else if (cnt < SREF_LAST || !self_q) begin
            cnt <= cnt + 1'b1;
          end
        end
        EN_PRE: begin
          if (cnt == pre_last) begin
            st   <= EN_IDLE;
            cnt  <= '0;
            done <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= EN_IDLE;
      endcase
    end
  end

  assert_cas_before_ras_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> (!cas_n && $past(!cas_n)));

  assert_cas_covers_ras_R4: assert property (@(posedge clk) disable iff (rst)
    !ras_n |-> !cas_n);

  assert_strobes_rise_together_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(ras_n) |-> $rose(cas_n));

  assert_precharge_kept_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(ras_n) |=> ras_n);

  assert_start_when_idle_R8: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq #(
  parameter int INTERVAL   = 1950,
  parameter int PAUSE_CYC  = 25000,
  parameter int WARM_CYC   = 8,
  parameter int MAX_PEND   = 8,
  parameter int CAS_LEAD   = 1,
  parameter int RAS_LOW    = 8,
  parameter int PRE_CYC    = 5,
  parameter int SREF_MIN   = 12500,
  parameter int SR_PRE_CYC = 14
) (
  input  logic clk,
  input  logic rst,
  input  logic lp_req,
  input  logic bus_gnt,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic bus_req,
  output logic init_done
);
  import drs_pkg::*;

  localparam int PW = $clog2(PAUSE_CYC + 1);
  localparam int WW = $clog2(WARM_CYC + 1);
  localparam logic [PW-1:0] P_LAST = PW'(PAUSE_CYC - 1);
  localparam logic [WW-1:0] W_LAST = WW'(WARM_CYC - 1);

  seq_state_t     state;
  logic [PW-1:0]  pause_cnt;
  logic [WW-1:0]  warm_cnt;
  logic           init_q;
  logic           we_q;

  logic tick, pend_any;
  logic eng_start, eng_self, eng_busy, eng_done, eng_can;

  drs_tick_timer #(.INTERVAL(INTERVAL)) u_timer (
    .clk (clk),
    .rst (rst),
    .en  (state == SQ_RUN),
    .tick(tick)
  );

  drs_pend_ctr #(.MAX_PEND(MAX_PEND)) u_pend (
    .clk(clk),
    .rst(rst),
    .clr(state != SQ_RUN),
    .inc(tick),
    .dec(eng_done),
    .any(pend_any)
  );

  drs_cbr_engine #(
    .CAS_LEAD  (CAS_LEAD),
    .RAS_LOW   (RAS_LOW),
    .PRE_CYC   (PRE_CYC),
    .SREF_MIN  (SREF_MIN),
    .SR_PRE_CYC(SR_PRE_CYC)
  ) u_engine (
    .clk      (clk),
    .rst      (rst),
    .start    (eng_start),
    .self_mode(eng_self),
    .hold     (lp_req),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .busy     (eng_busy),
    .done     (eng_done)
  );

  assign eng_can = !eng_busy && !eng_done;

  always_comb begin
    eng_start = 1'b0;
    eng_self  = 1'b0;
    unique case (state)
      SQ_WARM:               eng_start = eng_can;
      SQ_RUN:                eng_start = eng_can && pend_any && bus_gnt && !lp_req;
      SQ_SR_PRE, SQ_SR_POST: eng_start = eng_can && bus_gnt;
      SQ_SR_IN: begin
        eng_start = eng_can && bus_gnt;
        eng_self  = 1'b1;
      end
      default: eng_start = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SQ_PAUSE;
      pause_cnt <= '0;
      warm_cnt  <= '0;
      init_q    <= 1'b0;
      we_q      <= 1'b1;
    end else begin
      we_q <= 1'b1;
      unique case (state)
        SQ_PAUSE: begin
          if (pause_cnt == P_LAST) state <= SQ_WARM;
          else                     pause_cnt <= pause_cnt + 1'b1;
        end
        SQ_WARM: begin
          if (eng_done) begin
            warm_cnt <= warm_cnt + 1'b1;
            if (warm_cnt == W_LAST) begin
              state  <= SQ_RUN;
              init_q <= 1'b1;
            end
          end
        end
        SQ_RUN:     if (lp_req && eng_can) state <= SQ_SR_PRE;
        SQ_SR_PRE:  if (eng_done) state <= SQ_SR_IN;
        SQ_SR_IN:   if (eng_done) state <= SQ_SR_POST;
        SQ_SR_POST: if (eng_done) state <= SQ_RUN;
        default:    state <= SQ_PAUSE;
      endcase
    end
  end

  assign we_n      = we_q;
  assign init_done = init_q;
  assign bus_req   = (state != SQ_RUN) || pend_any || eng_busy;

  assert_we_high_at_ras_fall_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> we_n);

  assert_quiet_in_pause_R2: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_PAUSE) |-> (ras_n && cas_n));

  assert_bus_held_in_init_R2: assert property (@(posedge clk) disable iff (rst)
    !init_done |-> bus_req);

  assert_init_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);

  assert_grant_for_start_R8: assert property (@(posedge clk) disable iff (rst)
    (eng_start && state != SQ_WARM) |-> bus_gnt);

  assert_self_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_SR_IN && !ras_n && lp_req) |=> !ras_n);

endmodule

// File: tb/tb_dram_refresh_seq.sv
`timescale 1ns/1ps
module tb_dram_refresh_seq;
  localparam int INTERVAL   = 40;
  localparam int PAUSE_CYC  = 30;
  localparam int WARM_CYC   = 8;
  localparam int MAX_PEND   = 3;
  localparam int CAS_LEAD   = 2;
  localparam int RAS_LOW    = 4;
  localparam int PRE_CYC    = 3;
  localparam int SREF_MIN   = 25;
  localparam int SR_PRE_CYC = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lp  = 1'b0;
  logic gnt = 1'b1;
  logic ras_n, cas_n, we_n, bus_req, init_done;

  always #4 clk = ~clk;

  dram_refresh_seq #(
    .INTERVAL(INTERVAL), .PAUSE_CYC(PAUSE_CYC), .WARM_CYC(WARM_CYC),
    .MAX_PEND(MAX_PEND), .CAS_LEAD(CAS_LEAD), .RAS_LOW(RAS_LOW),
    .PRE_CYC(PRE_CYC), .SREF_MIN(SREF_MIN), .SR_PRE_CYC(SR_PRE_CYC)
  ) dut (
    .clk(clk), .rst(rst), .lp_req(lp), .bus_gnt(gnt),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .bus_req(bus_req), .init_done(init_done)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model: phase numbers and countdowns
  int ph, pcnt, wdone, tmr, pend, e, left;
  bit eself, edone, m_ras, m_cas, m_idone, started;

  always @(posedge clk) begin
    if (rst) begin
      ph = 0; pcnt = 0; wdone = 0; tmr = 0; pend = 0; e = 0; left = 0;
      eself = 0; edone = 0; m_ras = 1; m_cas = 1; m_idone = 0; started = 1;
    end else begin
      bit can, st, ss, nd, tick;
      int nph;
      can = (e == 0) && !edone;
      st = 0; ss = 0;
      case (ph)
        1: st = can;
        2: st = can && (pend > 0) && gnt && !lp;
        3, 5: st = can && gnt;
        4: begin st = can && gnt; ss = 1; end
        default: st = 0;
      endcase
      nph = ph;
      case (ph)
        0: begin pcnt++; if (pcnt == PAUSE_CYC) nph = 1; end
        1: if (edone) begin
             wdone++;
             if (wdone == WARM_CYC) begin nph = 2; m_idone = 1; end
           end
        2: if (lp && e == 0 && !edone) nph = 3;
        3: if (edone) nph = 4;
        4: if (edone) nph = 5;
        5: if (edone) nph = 2;
        default: nph = ph;
      endcase
      if (ph == 2) begin
        tick = (tmr == INTERVAL - 1);
        tmr  = tick ? 0 : tmr + 1;
        pend = pend + (tick ? 1 : 0) - (edone ? 1 : 0);
        if (pend > MAX_PEND) pend = MAX_PEND;
      end else begin
        tmr = 0; pend = 0;
      end
      nd = 0;
      case (e)
        0: if (st) begin e = 1; left = CAS_LEAD; m_cas = 0; eself = ss; end
        1: begin
             left--;
             if (left == 0) begin e = 2; m_ras = 0; left = eself ? SREF_MIN : RAS_LOW; end
           end
        2: if (eself) begin
             if (left > 1) left--;
             else if (!lp) begin e = 3; m_ras = 1; m_cas = 1; left = SR_PRE_CYC; end
           end else begin
             left--;
             if (left == 0) begin e = 3; m_ras = 1; m_cas = 1; left = PRE_CYC; end
           end
        3: begin left--; if (left == 0) begin e = 0; nd = 1; end end
        default: e = 0;
      endcase
      edone = nd;
      ph = nph;
    end
  end

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (started) begin
      chk(ras_n == m_ras, "R4 ras_n vs model", ras_n, m_ras);
      chk(cas_n == m_cas, "R4 cas_n vs model", cas_n, m_cas);
      chk(we_n == 1'b1, "R5 we_n", we_n, 1);
      chk(bus_req == ((ph != 2) || (pend > 0) || (e != 0)), "R7 bus_req vs model",
          bus_req, (ph != 2) || (pend > 0) || (e != 0));
      chk(init_done == m_idone, "R3 init_done vs model", init_done, m_idone);
    end
  end

  // Strobe monitor: pulse lengths and edge conditions
  int falls = 0;
  int low_run = 0, high_run = 0, cas_run = 0;
  int lows[$];
  int highs[$];
  bit prev_ras = 1'b1;

  always @(negedge clk) begin
    if (!rst) begin
      cas_run = cas_n ? 0 : cas_run + 1;
      if (prev_ras && !ras_n) begin
        falls++;
        highs.push_back(high_run);
        chk(we_n == 1'b1, "R5 we_n at ras fall", we_n, 1);
        chk(cas_run == CAS_LEAD + 1, "R4 cas lead at ras fall", cas_run, CAS_LEAD + 1);
        low_run = 0;
      end
      if (!prev_ras && ras_n) begin
        lows.push_back(low_run);
        high_run = 0;
      end
      if (ras_n) high_run++; else low_run++;
      prev_ras = ras_n;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    int f0;
    step(3);
    chk(ras_n && cas_n && we_n, "R1 strobes high in reset", {ras_n, cas_n, we_n}, 7);
    chk(!init_done, "R1 init_done low in reset", init_done, 0);
    chk(bus_req, "R1 bus_req high in reset", bus_req, 1);
    rst = 1'b0;
    lp  = 1'b1;                         // ignored before init_done (R2)
    step(1);
    chk(ras_n && cas_n && bus_req && !init_done, "R1 first cycle after reset",
        {ras_n, cas_n, bus_req, init_done}, 14);
    step(PAUSE_CYC - 2);
    chk(falls == 0 && cas_n, "R2 no strobes during pause", falls, 0);
    chk(bus_req, "R2 bus held during pause", bus_req, 1);
    step(20);
    lp = 1'b0;
    while (!init_done) step(1);
    chk(falls == WARM_CYC, "R3 warm-up cycle count", falls, WARM_CYC);
    foreach (lows[i]) chk(lows[i] == RAS_LOW, "R6 warm-up ras low width", lows[i], RAS_LOW);
    for (int i = 1; i < highs.size(); i++)
      chk(highs[i] >= PRE_CYC, "R6 precharge width", highs[i], PRE_CYC);

    // Interval refresh with grant held
    f0 = falls;
    step(200);
    chk((falls - f0) >= 4 && (falls - f0) <= 6, "R7 refreshes per 200 cycles", falls - f0, 5);

    // Grant withheld: no strobes, owed refreshes saturate
    gnt = 1'b0;
    step(15);
    f0 = falls;
    step(240);
    chk(falls == f0, "R8 no strobes without grant", falls - f0, 0);
    chk(bus_req, "R7 bus_req while owed", bus_req, 1);
    gnt = 1'b1;
    f0 = falls;
    step(25);
    chk((falls - f0) == MAX_PEND, "R9 back-to-back after saturation", falls - f0, MAX_PEND);

    // Long self-refresh
    while (bus_req) step(1);
    lows.delete(); highs.delete();
    lp = 1'b1;
    step(59);
    chk(!ras_n && !cas_n, "R11 strobes held while lp_req high", {ras_n, cas_n}, 0);
    step(1);
    lp = 1'b0;
    step(45);
    chk(lows.size() >= 3, "R10 pulses around self-refresh", lows.size(), 3);
    if (lows.size() >= 3) begin
      chk(lows[0] == RAS_LOW, "R10 refresh before self-refresh", lows[0], RAS_LOW);
      chk(lows[1] >= 40, "R11 self-refresh covers request", lows[1], 40);
      chk(lows[2] == RAS_LOW, "R12 refresh after self-refresh", lows[2], RAS_LOW);
      chk(highs[2] >= SR_PRE_CYC, "R12 long precharge on exit", highs[2], SR_PRE_CYC);
    end

    // Short request: minimum self-refresh time
    while (bus_req) step(1);
    lows.delete(); highs.delete();
    lp = 1'b1;
    step(3);
    lp = 1'b0;
    step(80);
    chk(lows.size() >= 3, "R11 pulses for short request", lows.size(), 3);
    if (lows.size() >= 3) begin
      chk(lows[1] == SREF_MIN, "R11 minimum self-refresh", lows[1], SREF_MIN);
      chk(highs[2] >= SR_PRE_CYC, "R12 long precharge after minimum", highs[2], SR_PRE_CYC);
      chk(lows[2] == RAS_LOW, "R12 refresh after minimum", lows[2], RAS_LOW);
    end
    step(60);
    chk(init_done, "R3 init_done stays high", init_done, 1);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule